// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counters that share one byte-wide register bus. Each timer has a low byte, a high byte and a four-bit configuration field. The field picks the counting mode, the count source and gating. The count source is either an internal machine-cycle tick or falling edges on an external pin. With gating on, the timer advances only while an external enable pin is high, so the count measures how long that pin stays high. When a timer wraps, it sets its overflow flag. Software reads the flag and clears it by writing zero.

There are four modes. Mode 0 is a 13-bit count: five low-byte bits act as a prescaler below the full high byte. Mode 1 is a 16-bit count. Mode 2 is an 8-bit count in the low byte that reloads from the high byte when it wraps. Mode 3 exists on timer 0 only. It turns timer 0 into two separate 8-bit timers, and the upper one takes over the run bit and flag of timer 1. Timer 1 in mode 3 holds its count.

The external count pin and the gate pin are each passed through a two-flip-flop synchronizer before the counting logic uses them.

Top module: `tmr_pair`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero: run bits, flags, configuration and all four count bytes.
- R2: Mode 1 (mode code 1) advances {high,low} by one per count event. On the step from 0xFFFF to 0x0000 it sets the timer's flag. This holds for both timers.
- R3: Mode 0 (mode code 0) counts low-byte bits [4:0] as a prescaler and increments the high byte when they wrap. Low-byte bits [7:5] are left unchanged. The flag is set on the step from high 0xFF with low[4:0] 0x1F.
- R4: Mode 2 (mode code 2) increments the low byte. When the low byte is 0xFF, the next event loads it from the high byte and sets the flag. The high byte does not change.
- R5: Timer 0 in mode 3 (mode code 3) counts its low byte under run bit 0 and sets flag 0. Its high byte counts internal ticks under run bit 1 and alone sets flag 1 when it wraps from 0xFF. An overflow of timer 1 then leaves flag 1 unchanged.
- R6: Timer 1 in mode 3 holds both of its count bytes.
- R7: With the source bit set, the timer counts falling edges of its count pin. A falling edge driven before clock edge k advances the count at edge k+2. A rising edge does not count.
- R8: With the gate bit set, the timer counts only while its gate pin, after synchronization, is high.
- R9: With the run bit clear, the count stays unchanged.
- R10: A write to the control register replaces the flags with the written bits, so writing zero clears a flag. A hardware overflow in the same cycle wins and leaves the flag set.
- R11: A bus write to a count byte loads that byte. In that cycle the write replaces the count step of that timer: both bytes in modes 0 to 2, and only the written byte in split mode.
- R12: Register map by address: 0 control (bit0 run0, bit1 run1, bit4 flag0, bit5 flag1, other bits read 0); 1 configuration ([1:0] mode, [2] source, [3] gate for timer 0; [7:4] the same for timer 1); 2/3 timer 0 low/high; 4/5 timer 1 low/high; 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Internal machine-cycle count enable |
| cnt_pin_i | input | 2 | External count pins, one per timer (asynchronous) |
| gate_pin_i | input | 2 | External gate pins, one per timer (asynchronous) |
| sfr_addr_i | input | 3 | Register address |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_wdata_i | input | 8 | Register write data |
| sfr_rdata_o | output | 8 | Register read data for the addressed register (combinational) |
| flag_o | output | 2 | Overflow flags of timer 0 and timer 1 |

## Verification
The following are checked on every cycle:
- the mode-2 reload taking the high byte;
- the 16-bit wrap going to zero;
- a bus write loading its byte;
- an idle timer holding its count;
- timer 1 holding in mode 3;
- a detected falling edge lasting one cycle;
- a flag following each overflow;
- flag 1 being owned by the split high byte.

The bench's scenarios are needed for the rest:
- the exact counts and final values in each mode;
- the two-cycle latency of the pin synchronizer;
- rising edges and a low gate being ignored;
- set-over-clear priority on the flags;
- the register map itself.

// File: rtl/tmr_pkg.sv
// Package: shared types and register addresses for the dual timer unit.
// Assumes a 3-bit register address space and 8-bit data.
package tmr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        TM_13    = 2'd0,
        TM_16    = 2'd1,
        TM_RLD8  = 2'd2,
        TM_SPLIT = 2'd3
    } tmr_mode_e;

    // One timer's configuration nibble: [3] gate, [2] ext source, [1:0] mode
    typedef struct packed {
        logic      gate;
        logic      ext;
        tmr_mode_e mode;
    } tmr_cfg_t;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TL0  = 3'd2;
endpackage

// File: rtl/tmr_sync.sv
// Module: tmr_sync
// Brings one asynchronous pin into the clock domain through STAGES flops.
// With FALL_DETECT=1 the output is a one-cycle pulse per 1-to-0 transition
// of the synchronized level; otherwise it is the synchronized level.
// Assumes STAGES >= 2.
module tmr_sync #(
    parameter int STAGES      = 2,
    parameter bit FALL_DETECT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic out_o
);
    logic [STAGES-1:0] sh_q;

    // Shift the pin through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], pin_i};
    end

    generate
        if (FALL_DETECT) begin : g_fall
            logic prev_q;

            // Remember the previous synchronized sample
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= sh_q[STAGES-1];
            end

            assign out_o = prev_q & ~sh_q[STAGES-1];

            AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                out_o |=> !out_o); // R7
        end else begin : g_level
            assign out_o = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tmr_core.sv
// Module: tmr_core
// One timer: low and high count bytes with four counting modes.
// inc_main_i steps the main count, and inc_hi_i steps the high byte in split
// mode. A bus write to a byte replaces the count step (see R11).
// HAS_SPLIT=0 makes mode 3 hold the count. Assumes PRE_BITS < BYTE_W.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int PRE_BITS  = 5,
    parameter bit HAS_SPLIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode_i,
    input  logic              inc_main_i,
    input  logic              inc_hi_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              ovf_main_o,
    output logic              ovf_hi_o
);
    localparam int W2 = 2 * BYTE_W;
    localparam logic [W2-1:0]       ONE2 = {{(W2-1){1'b0}}, 1'b1};
    localparam logic [BYTE_W-1:0]   ONE1 = {{(BYTE_W-1){1'b0}}, 1'b1};
    localparam logic [PRE_BITS-1:0] ONEP = {{(PRE_BITS-1){1'b0}}, 1'b1};

    logic [BYTE_W-1:0]   lo_q, hi_q, lo_n, hi_n;
    logic [PRE_BITS-1:0] pre;
    logic [W2-1:0]       cnt_inc;
    logic                blk;

    assign pre     = lo_q[PRE_BITS-1:0];
    assign cnt_inc = {hi_q, lo_q} + ONE2;
    assign blk     = wr_lo_i | wr_hi_i;

    // Next-state count and overflow pulses for the selected mode
    always_comb begin
        lo_n       = lo_q;
        hi_n       = hi_q;
        ovf_main_o = 1'b0;
        ovf_hi_o   = 1'b0;
        case (mode_i)
            TM_13: if (inc_main_i && !blk) begin
                if (&pre) begin
                    lo_n[PRE_BITS-1:0] = '0;
                    hi_n               = hi_q + ONE1;
                    ovf_main_o         = &hi_q;
                end else begin
                    lo_n[PRE_BITS-1:0] = pre + ONEP;
                end
            end
            TM_16: if (inc_main_i && !blk) begin
                {hi_n, lo_n} = cnt_inc;
                ovf_main_o   = &{hi_q, lo_q};
            end
            TM_RLD8: if (inc_main_i && !blk) begin
                ovf_main_o = &lo_q;
                lo_n       = (&lo_q) ? hi_q : lo_q + ONE1;
            end
            TM_SPLIT: if (HAS_SPLIT) begin
                if (inc_main_i && !wr_lo_i) begin
                    lo_n       = lo_q + ONE1;
                    ovf_main_o = &lo_q;
                end
                if (inc_hi_i && !wr_hi_i) begin
                    hi_n     = hi_q + ONE1;
                    ovf_hi_o = &hi_q;
                end
            end
            default: ;
        endcase
        if (wr_lo_i) lo_n = wdata_i;
        if (wr_hi_i) hi_n = wdata_i;
    end

    // Count byte registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign lo_o = lo_q;
    assign hi_o = hi_q;

    AST_RLD8_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_RLD8 && inc_main_i && !blk && &lo_q) |=> (lo_q == $past(hi_q))); // R4
    AST_M16_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == TM_16 && inc_main_i && !blk && &{hi_q, lo_q}) |=> ({hi_q, lo_q} == '0)); // R2
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> (lo_q == $past(wdata_i))); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_main_i && !inc_hi_i && !blk) |=> ($stable(lo_q) && $stable(hi_q))); // R9

    generate
        if (!HAS_SPLIT) begin : g_nosplit
            AST_NO_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == TM_SPLIT && !blk) |=> ($stable(lo_q) && $stable(hi_q))); // R6
        end
    endgenerate
endmodule

// File: rtl/tmr_pair.sv
// Module: tmr_pair (top)
// Two timer/counters behind one byte-wide register bus. Holds run bits,
// flags and configuration, qualifies count events (run, gate, source) and
// routes overflows to flags. Timer 0 alone supports split mode. Its high
// byte then uses run bit 1 and flag 1. Reads are combinational.
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PRE_BITS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [1:0]        cnt_pin_i,
    input  logic [1:0]        gate_pin_i,
    input  logic [ADDR_W-1:0] sfr_addr_i,
    input  logic              sfr_we_i,
    input  logic [DATA_W-1:0] sfr_wdata_i,
    output logic [DATA_W-1:0] sfr_rdata_o,
    output logic [1:0]        flag_o
);
    localparam int N_TMR = 2;
    localparam int CFG_W = $bits(tmr_cfg_t);

    logic [N_TMR-1:0]  run_q, flag_q, set_flag;
    logic [DATA_W-1:0] mode_q;
    logic [N_TMR-1:0]  fall_w, gate_w, inc_w, ovf_main_w, ovf_hi_w;
    logic [DATA_W-1:0] lo_w [N_TMR];
    logic [DATA_W-1:0] hi_w [N_TMR];
    tmr_cfg_t          cfg  [N_TMR];
    logic              split0, wr_ctrl;

    assign wr_ctrl = sfr_we_i && (sfr_addr_i == ADDR_CTRL);

    generate
        for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
            localparam logic [ADDR_W-1:0] A_LO = ADDR_TL0 + ADDR_W'(2 * i);
            localparam logic [ADDR_W-1:0] A_HI = A_LO + ADDR_W'(1);
            logic inc_hi;

            assign cfg[i] = tmr_cfg_t'(mode_q[CFG_W*i +: CFG_W]);

            tmr_sync #(.STAGES(SYNC_STAGES), .FALL_DETECT(1'b1)) u_cnt_sync (
                .clk(clk), .rst_n(rst_n), .pin_i(cnt_pin_i[i]), .out_o(fall_w[i]));
            tmr_sync #(.STAGES(SYNC_STAGES), .FALL_DETECT(1'b0)) u_gate_sync (
                .clk(clk), .rst_n(rst_n), .pin_i(gate_pin_i[i]), .out_o(gate_w[i]));

            assign inc_w[i] = run_q[i] && (!cfg[i].gate || gate_w[i])
                              && (cfg[i].ext ? fall_w[i] : tick_i);
            assign inc_hi   = (i == 0) ? (run_q[N_TMR-1] & tick_i) : 1'b0;

            tmr_core #(.BYTE_W(DATA_W), .PRE_BITS(PRE_BITS), .HAS_SPLIT(i == 0)) u_core (
                .clk        (clk),
                .rst_n      (rst_n),
                .mode_i     (cfg[i].mode),
                .inc_main_i (inc_w[i]),
                .inc_hi_i   (inc_hi),
                .wr_lo_i    (sfr_we_i && sfr_addr_i == A_LO),
                .wr_hi_i    (sfr_we_i && sfr_addr_i == A_HI),
                .wdata_i    (sfr_wdata_i),
                .lo_o       (lo_w[i]),
                .hi_o       (hi_w[i]),
                .ovf_main_o (ovf_main_w[i]),
                .ovf_hi_o   (ovf_hi_w[i])
            );
        end
    endgenerate

    assign split0      = (cfg[0].mode == TM_SPLIT);
    assign set_flag[0] = ovf_main_w[0];
    // timer 1 never raises a split-high overflow, so OR-ing both is exact
    assign set_flag[1] = split0 ? (|ovf_hi_w) : ovf_main_w[1];

    // Control and configuration registers; hardware flag set beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            flag_q <= '0;
            mode_q <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= sfr_wdata_i[1:0];
                flag_q <= sfr_wdata_i[5:4] | set_flag;
            end else begin
                flag_q <= flag_q | set_flag;
            end
            if (sfr_we_i && sfr_addr_i == ADDR_MODE) mode_q <= sfr_wdata_i;
        end
    end

    // Read-back multiplexer over the register map
    always_comb begin
        sfr_rdata_o = '0;
        if (sfr_addr_i == ADDR_CTRL) sfr_rdata_o = {2'b00, flag_q, 2'b00, run_q};
        if (sfr_addr_i == ADDR_MODE) sfr_rdata_o = mode_q;
        for (int i = 0; i < N_TMR; i++) begin
            if (sfr_addr_i == ADDR_TL0 + ADDR_W'(2 * i))     sfr_rdata_o = lo_w[i];
            if (sfr_addr_i == ADDR_TL0 + ADDR_W'(2 * i + 1)) sfr_rdata_o = hi_w[i];
        end
    end

    assign flag_o = flag_q;

    AST_FLAG0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_main_w[0] |=> flag_q[0]); // R10
    AST_FLAG1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_flag[1] |=> flag_q[1]); // R10
    AST_SPLIT_OWNS_FLAG1: assert property (@(posedge clk) disable iff (!rst_n)
        (split0 && !ovf_hi_w[0] && !wr_ctrl) |=> (flag_q[1] == $past(flag_q[1]))); // R5
endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] cnt_pin_i = 2'b11;
    logic [1:0] gate_pin_i = 2'b00;
    logic [2:0] sfr_addr_i = 3'd0;
    logic       sfr_we_i = 1'b0;
    logic [7:0] sfr_wdata_i = 8'h00;
    logic [7:0] sfr_rdata_o;
    logic [1:0] flag_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    tmr_pair dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_pin_i(cnt_pin_i),
        .gate_pin_i(gate_pin_i), .sfr_addr_i(sfr_addr_i), .sfr_we_i(sfr_we_i),
        .sfr_wdata_i(sfr_wdata_i), .sfr_rdata_o(sfr_rdata_o), .flag_o(flag_o));

    localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_T0L = 3'd2,
                           A_T0H = 3'd3, A_T1L = 3'd4, A_T1H = 3'd5;

    // {mode, preset lo, preset hi, ticks, expected lo, expected hi, expected ctrl&0x10}
    localparam int NV = 8;
    localparam logic [55:0] VEC [NV] = '{
        {8'h01, 8'h00, 8'h00, 8'd5, 8'h05, 8'h00, 8'h00},
        {8'h01, 8'hFE, 8'hFF, 8'd3, 8'h01, 8'h00, 8'h10},
        {8'h01, 8'hFF, 8'h00, 8'd1, 8'h00, 8'h01, 8'h00},
        {8'h00, 8'hFE, 8'h00, 8'd3, 8'hE1, 8'h01, 8'h00},
        {8'h00, 8'h1F, 8'hFF, 8'd1, 8'h00, 8'h00, 8'h10},
        {8'h02, 8'hFE, 8'h80, 8'd3, 8'h81, 8'h80, 8'h10},
        {8'h02, 8'h10, 8'hF0, 8'd2, 8'h12, 8'hF0, 8'h00},
        {8'h03, 8'hFF, 8'h33, 8'd2, 8'h01, 8'h33, 8'h10}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        sfr_addr_i = a; sfr_wdata_i = d; sfr_we_i = 1'b1;
        @(negedge clk);
        sfr_we_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        sfr_addr_i = a;
        #1;
        d = sfr_rdata_o;
    endtask

    task automatic ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every address
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R1 reset", d, 8'h00);
        end

        // Vector table for timer 0 on internal ticks
        for (int v = 0; v < NV; v++) begin
            logic [55:0] e;
            string tg;
            e = VEC[v];
            case (e[49:48])
                2'd0: tg = "R3 mode0";
                2'd1: tg = "R2 mode1";
                2'd2: tg = "R4 mode2";
                default: tg = "R5 split low";
            endcase
            wr(A_CTRL, 8'h00);
            wr(A_MODE, e[55:48]);
            wr(A_T0L, e[47:40]);
            wr(A_T0H, e[39:32]);
            wr(A_CTRL, 8'h01);
            ticks(int'(e[31:24]));
            rd(A_T0L, d);  chk(tg, d, e[23:16]);
            rd(A_T0H, d);  chk(tg, d, e[15:8]);
            rd(A_CTRL, d); chk(tg, d & 8'h10, e[7:0]);
        end

        // R5 / R6: split high byte and timer 1 hold in mode 3
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h33);
        wr(A_T0L, 8'h77); wr(A_T0H, 8'hFE);
        wr(A_T1L, 8'h55); wr(A_T1H, 8'hAA);
        wr(A_CTRL, 8'h02);
        ticks(3);
        rd(A_T0H, d);  chk("R5 split high count", d, 8'h01);
        rd(A_T0L, d);  chk("R5 split low idle", d, 8'h77);
        rd(A_CTRL, d); chk("R5 flag1 from split high", d, 8'h22);
        rd(A_T1L, d);  chk("R6 timer1 hold lo", d, 8'h55);
        rd(A_T1H, d);  chk("R6 timer1 hold hi", d, 8'hAA);

        // R5: timer 1 overflow leaves flag 1 alone while timer 0 is split
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h13);
        wr(A_T1L, 8'hFF); wr(A_T1H, 8'hFF); wr(A_T0H, 8'h00);
        wr(A_CTRL, 8'h02);
        ticks(1);
        rd(A_T1L, d);  chk("R5 timer1 wraps", d, 8'h00);
        rd(A_CTRL, d); chk("R5 flag1 not from timer1", d, 8'h02);

        // R2: timer 1 in mode 1 sets flag 1
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h10);
        wr(A_T1L, 8'hFF); wr(A_T1H, 8'hFF);
        wr(A_CTRL, 8'h02);
        ticks(1);
        rd(A_T1H, d);  chk("R2 timer1 wrap hi", d, 8'h00);
        rd(A_CTRL, d); chk("R2 timer1 flag", d, 8'h22);

        // R7: falling-edge counting and its latency
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h05);
        wr(A_T0L, 8'h00); wr(A_T0H, 8'h00);
        wr(A_CTRL, 8'h01);
        sfr_addr_i = A_T0L;
        cnt_pin_i[0] = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R7 not yet at k+1", sfr_rdata_o, 8'h00);
        @(posedge clk); #1;
        chk("R7 counted at k+2", sfr_rdata_o, 8'h01);
        @(negedge clk);
        cnt_pin_i[0] = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_T0L, d); chk("R7 rising ignored", d, 8'h01);
        cnt_pin_i[0] = 1'b0;
        repeat (4) @(negedge clk);
        rd(A_T0L, d); chk("R7 second fall", d, 8'h02);

        // R8: gated counting
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h09);
        wr(A_T0L, 8'h00); wr(A_T0H, 8'h00);
        wr(A_CTRL, 8'h01);
        ticks(5);
        rd(A_T0L, d); chk("R8 gate low blocks", d, 8'h00);
        gate_pin_i[0] = 1'b1;
        repeat (3) @(negedge clk);
        ticks(4);
        rd(A_T0L, d); chk("R8 gate high counts", d, 8'h04);
        gate_pin_i[0] = 1'b0;

        // R9: run bit clear
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h01);
        ticks(5);
        rd(A_T0L, d); chk("R9 stopped", d, 8'h04);

        // R10: clear by zero, and set wins over same-cycle clear
        wr(A_T0L, 8'hFF); wr(A_T0H, 8'hFF);
        wr(A_CTRL, 8'h01);
        tick_i = 1'b1;
        wr(A_CTRL, 8'h01);
        tick_i = 1'b0;
        rd(A_CTRL, d); chk("R10 set beats clear", d, 8'h11);
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, d); chk("R10 write zero clears", d, 8'h01);

        // R11: bus write replaces the count step
        wr(A_T0L, 8'h10); wr(A_T0H, 8'h00);
        tick_i = 1'b1;
        @(negedge clk);
        wr(A_T0L, 8'h40);
        tick_i = 1'b0;
        rd(A_T0L, d); chk("R11 write wins lo", d, 8'h40);
        rd(A_T0H, d); chk("R11 hi untouched", d, 8'h00);
        ticks(1);
        rd(A_T0L, d); chk("R11 resumes", d, 8'h41);

        // R12: register map read-back
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'hA6);
        rd(A_MODE, d); chk("R12 mode readback", d, 8'hA6);
        wr(A_MODE, 8'h00);
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, d); chk("R12 ctrl bits", d, 8'h33);
        chk("R12 flag port", {6'd0, flag_o}, 8'h03);
        rd(3'd6, d); chk("R12 unused addr", d, 8'h00);
        wr(A_CTRL, 8'h00);

        // R1: reset clears again
        wr(A_T1L, 8'h99);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_T1L, d); chk("R1 re-reset", d, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule